// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block takes decoded transport packets from an upstream decoder, one byte at a time, and drives them onto an output port. The port carries an output clock, a data bus, a data-valid strobe, a sync strobe and an uncorrectable-packet flag. Input bytes arrive with valid, start-of-packet and uncorrectable sideband signals. A ready signal paces the upstream, because the port accepts at most one byte per output beat.

In parallel mode a whole byte leaves on the bus in each output beat. In serial mode each byte leaves on bus bit 0 over eight beats, most significant bit first. One output beat lasts two core clocks. A configuration input chooses whether data changes on the rising or on the falling edge of the output clock. Bytes outside a packet are consumed and discarded, and leave no trace on the port. A packet is a start-of-packet byte followed by at most 187 further bytes. While nothing is being sent, every strobe stays low and the bus keeps its last value.

Top module: `ts_out_fmt`

## Requirements
- R1: After the active-low asynchronous reset, ts_valid_o, ts_sync_o and ts_err_o are low and ts_data_o is zero.
- R2: With cfg_serial_i low, each accepted packet byte appears whole on ts_data_o for exactly one output beat with ts_valid_o high.
- R3: With cfg_serial_i high, each accepted packet byte appears on ts_data_o[0] over 8 consecutive beats, MSB first, with ts_data_o[7:1] zero and ts_valid_o high on all 8 beats.
- R4: ts_sync_o is high on the beat(s) of a byte accepted with in_sop_i high, and low on every other beat.
- R5: ts_err_o is high on every beat of a packet whose start byte was accepted with in_uncor_i high, and low on the beats of every other packet. in_uncor_i is sampled only with the start byte.
- R6: A packet is at most 188 bytes. A byte accepted without in_sop_i high when no packet is open produces no output beat with ts_valid_o high. This covers a byte before the first start and a byte after the 188th.
- R7: A byte accepted with in_sop_i high while a packet is open starts a new packet. The new packet has a fresh 188-byte count and a fresh error flag.
- R8: On a beat with no byte to send, ts_valid_o, ts_sync_o and ts_err_o are low and ts_data_o keeps its previous value.
- R9: ts_clk_o has a period of two core clocks. Port outputs change only at a launch edge: the rising edge of ts_clk_o when cfg_fall_i is low, the falling edge when it is high.
- R10: The start byte is passed through unchanged whatever its value (nominally 0x47).
- R11: in_ready_o is high in at most one core clock per beat. In serial mode it is high at most once per 8 beats while a byte is being shifted. A byte is taken when in_valid_i and in_ready_o are both high at a clock edge.
- R12: cfg_serial_i and cfg_fall_i change only while no packet is open and no byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Byte from the decoder |
| in_valid_i | input | 1 | in_data_i holds a byte |
| in_sop_i | input | 1 | Byte is the first byte of a packet |
| in_uncor_i | input | 1 | Packet could not be corrected (sampled with start byte) |
| in_ready_o | output | 1 | Byte is taken at this clock edge if valid |
| cfg_serial_i | input | 1 | 1: bit-serial on bit 0, 0: byte-parallel |
| cfg_fall_i | input | 1 | 1: launch on falling output-clock edge |
| ts_clk_o | output | 1 | Output clock |
| ts_data_o | output | 8 | Output data bus |
| ts_valid_o | output | 1 | Packet data on the bus |
| ts_sync_o | output | 1 | Start byte on the bus |
| ts_err_o | output | 1 | Current packet is uncorrectable |

## Verification
Two events can fall on the same beat: the end of a packet and the start of the next one. In that case the close of the 188-byte count and the arrival of a new start byte with a different error flag land in one acceptance. The bench provokes this in two ways. It sends packets back to back, and it cuts a packet short with a new start byte. It then judges each beat at the port: the sync strobe and error flag must switch to the new packet exactly on its first byte, and a byte after a full packet must vanish. A beat monitor rebuilds serial bytes and compares every beat with a queue of expected bytes computed in the bench.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;
  typedef struct packed {
    logic       err;
    logic       sync;
    logic       valid;
  } ts_flags_t;
endpackage

// File: rtl/ts_beat_gen.sv
module ts_beat_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_fall_i,
  output logic tick_o,
  output logic ts_clk_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  // last core clock of a beat; outputs reload at the following edge
  assign tick_o   = ph_q;
  assign ts_clk_o = launch_fall_i ? ph_q : ~ph_q;

  // R9
  beat_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ph_q != $past(ph_q)));
endmodule

// File: rtl/ts_pkt_tracker.sv
module ts_pkt_tracker #(
  parameter int PKT_LEN = 188
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic sop_i,
  input  logic uncor_i,
  output logic keep_o,
  output logic pkt_uncor_o,
  output logic in_pkt_o
);
  localparam int IW = $clog2(PKT_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(PKT_LEN - 1);

  logic [IW-1:0] idx_q;
  logic          in_pkt_q;
  logic          uncor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      in_pkt_q <= 1'b0;
      uncor_q  <= 1'b0;
    end else if (accept_i) begin
      if (sop_i) begin
        idx_q    <= IW'(1);
        in_pkt_q <= 1'b1;
        uncor_q  <= uncor_i;
      end else if (in_pkt_q) begin
        if (idx_q == LAST_IDX) begin
          idx_q    <= '0;
          in_pkt_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign keep_o      = sop_i | in_pkt_q;
  assign pkt_uncor_o = sop_i ? uncor_i : uncor_q;
  assign in_pkt_o    = in_pkt_q;

  // R6
  pkt_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  // R6
  closed_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_pkt_q |-> (idx_q == '0));
endmodule

// File: rtl/ts_serializer.sv
module ts_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              serial_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              can_take_o,
  output logic              step_o,
  output logic              busy_o,
  output logic              cur_bit_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] shift_q;
  logic [BW-1:0]     bit_idx_q;
  logic              busy_q;

  assign can_take_o = !busy_q || (bit_idx_q == LAST_BIT);
  assign step_o     = tick_i && busy_q && (bit_idx_q != LAST_BIT);
  assign busy_o     = busy_q;
  assign cur_bit_o  = load_i ? data_i[DATA_W-1] : shift_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q   <= '0;
      bit_idx_q <= '0;
      busy_q    <= 1'b0;
    end else if (tick_i) begin
      if (load_i && serial_i) begin
        shift_q   <= {data_i[DATA_W-2:0], 1'b0};
        bit_idx_q <= '0;
        busy_q    <= 1'b1;
      end else if (step_o) begin
        shift_q   <= {shift_q[DATA_W-2:0], 1'b0};
        bit_idx_q <= bit_idx_q + BW'(1);
      end else begin
        bit_idx_q <= '0;
        busy_q    <= 1'b0;
      end
    end
  end

  // R3
  shift_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && busy_q && bit_idx_q != LAST_BIT) |=>
      (busy_q && bit_idx_q == $past(bit_idx_q) + BW'(1)));
  // R11
  no_take_mid_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_idx_q != LAST_BIT) |-> !load_i);
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt #(
  parameter int DATA_W  = 8,
  parameter int PKT_LEN = 188
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_uncor_i,
  output logic              in_ready_o,
  input  logic              cfg_serial_i,
  input  logic              cfg_fall_i,
  output logic              ts_clk_o,
  output logic [DATA_W-1:0] ts_data_o,
  output logic              ts_valid_o,
  output logic              ts_sync_o,
  output logic              ts_err_o
);
  import ts_out_pkg::*;

  logic tick, accept, keep, pkt_uncor, in_pkt;
  logic can_take, step, busy, cur_bit;
  logic [DATA_W-1:0] data_q;
  ts_flags_t         flags_q;

  ts_beat_gen u_beat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_fall_i (cfg_fall_i),
    .tick_o        (tick),
    .ts_clk_o      (ts_clk_o)
  );

  ts_pkt_tracker #(.PKT_LEN(PKT_LEN)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .sop_i       (in_sop_i),
    .uncor_i     (in_uncor_i),
    .keep_o      (keep),
    .pkt_uncor_o (pkt_uncor),
    .in_pkt_o    (in_pkt)
  );

  ts_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .serial_i   (cfg_serial_i),
    .load_i     (accept && keep),
    .data_i     (in_data_i),
    .can_take_o (can_take),
    .step_o     (step),
    .busy_o     (busy),
    .cur_bit_o  (cur_bit)
  );

  assign in_ready_o = tick && (!cfg_serial_i || can_take);
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      flags_q <= '0;
    end else if (tick) begin
      if (accept && keep) begin
        data_q  <= cfg_serial_i ? {{(DATA_W-1){1'b0}}, cur_bit} : in_data_i;
        flags_q <= '{err: pkt_uncor, sync: in_sop_i, valid: 1'b1};
      end else if (step) begin
        data_q  <= {{(DATA_W-1){1'b0}}, cur_bit};
      end else begin
        flags_q <= '0;
      end
    end
  end

  assign ts_data_o  = data_q;
  assign ts_valid_o = flags_q.valid;
  assign ts_sync_o  = flags_q.sync;
  assign ts_err_o   = flags_q.err;

  // R4
  sync_in_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_sync_o |-> ts_valid_o);
  // R5
  err_in_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_err_o |-> ts_valid_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_valid_o ##1 !ts_valid_o |-> $stable(ts_data_o));
  // R9
  launch_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> ($stable(ts_data_o) && $stable(flags_q)));
  // R11
  ready_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);
  // R12
  cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pkt || busy) |=> ($stable(cfg_serial_i) && $stable(cfg_fall_i)));
endmodule

// File: tb/ts_out_fmt_tb_top.sv
module ts_out_fmt_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0, in_sop_i = 1'b0, in_uncor_i = 1'b0;
  logic       cfg_serial_i = 1'b0, cfg_fall_i = 1'b0;
  logic       in_ready_o, ts_clk_o, ts_valid_o, ts_sync_o, ts_err_o;
  logic [7:0] ts_data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [9:0] exp_mem [0:2047];
  int wr = 0, rd = 0;
  logic mon_en = 1'b0, prev_clk = 1'b0;
  logic [7:0] prev_beat_do, prev_do;
  logic prev_den;
  int   s_cnt = 0;
  logic [7:0] s_byte;
  logic s_sync, s_err;

  always #4 clk_i = ~clk_i;

  ts_out_fmt dut_i (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((i * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic pop_check(input logic [7:0] b, input logic sy, input logic er);
    if (rd == wr) begin
      chk(1'b0, "R6 unexpected byte", int'(b), 0);
    end else begin
      chk(b == exp_mem[rd][7:0], cfg_serial_i ? "R3 data" : "R2 data", int'(b), int'(exp_mem[rd][7:0]));
      chk(sy == exp_mem[rd][8], "R4 sync", int'(sy), int'(exp_mem[rd][8]));
      chk(er == exp_mem[rd][9], "R5 err", int'(er), int'(exp_mem[rd][9]));
      rd++;
    end
  endtask

  // beat monitor
  always @(negedge clk_i) if (mon_en) begin
    logic start;
    start = cfg_fall_i ? (prev_clk && !ts_clk_o) : (!prev_clk && ts_clk_o);
    prev_clk = ts_clk_o;
    if (!start) begin
      if (ts_data_o != prev_do || ts_valid_o != prev_den)
        chk(1'b0, "R9 change off launch edge", int'(ts_data_o), int'(prev_do));
    end else if (ts_valid_o) begin
      if (cfg_serial_i) begin
        chk(ts_data_o[7:1] == 7'd0, "R3 upper bits", int'(ts_data_o), int'(ts_data_o[0]));
        if (s_cnt == 0) begin s_sync = ts_sync_o; s_err = ts_err_o; s_byte = '0; end
        else chk(ts_sync_o == s_sync && ts_err_o == s_err, "R4 R5 held over bits",
                 int'({ts_sync_o, ts_err_o}), int'({s_sync, s_err}));
        s_byte = {s_byte[6:0], ts_data_o[0]};
        s_cnt++;
        if (s_cnt == 8) begin pop_check(s_byte, s_sync, s_err); s_cnt = 0; end
      end else begin
        pop_check(ts_data_o, ts_sync_o, ts_err_o);
      end
      prev_beat_do = ts_data_o;
    end else begin
      chk(!ts_sync_o && !ts_err_o && ts_data_o == prev_beat_do, "R8 idle beat",
          int'({ts_sync_o, ts_err_o, ts_data_o}), int'(prev_beat_do));
      if (s_cnt != 0) begin chk(1'b0, "R3 gap inside byte", s_cnt, 0); s_cnt = 0; end
    end
    prev_do = ts_data_o;
    prev_den = ts_valid_o;
  end

  task automatic idle(input int n);
    in_valid_i = 1'b0;
    for (int j = 0; j < n; j++) @(negedge clk_i);
  endtask

  // R11: byte taken at the edge after a negedge where ready is seen
  task automatic send(input logic [7:0] b, input logic sop, input logic unc, input logic expect_out);
    if (expect_out) begin
      exp_mem[wr] = {unc, sop, b};
      wr++;
    end
    in_data_i = b; in_sop_i = sop; in_uncor_i = unc; in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // n bytes of packet k; err flag unc sampled with start byte
  task automatic send_pkt(input int k, input int n, input logic [7:0] sync_b,
                          input logic unc, input int gap_every);
    logic pkt_err;
    pkt_err = unc;
    for (int i = 0; i < n; i++) begin
      if (i == 0) send(sync_b, 1'b1, unc, 1'b1);
      else begin
        // in_uncor_i toggled on body bytes must not matter (R5)
        exp_mem[wr] = {pkt_err, 1'b0, pat(k, i)}; wr++;
        in_data_i = pat(k, i); in_sop_i = 1'b0; in_uncor_i = ~unc; in_valid_i = 1'b1;
        while (!in_ready_o) @(negedge clk_i);
        @(negedge clk_i);
        in_valid_i = 1'b0;
      end
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(!ts_valid_o && !ts_sync_o && !ts_err_o && ts_data_o == 8'h00, "R1 reset",
        int'({ts_valid_o, ts_sync_o, ts_err_o, ts_data_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!ts_valid_o && ts_data_o == 8'h00, "R1 after release", int'(ts_data_o), 0);
    prev_clk = ts_clk_o; prev_do = ts_data_o; prev_den = ts_valid_o; prev_beat_do = ts_data_o;
    mon_en = 1'b1;

    // R6: stray byte before any start
    send(8'hAA, 1'b0, 1'b0, 1'b0);
    idle(4);
    // R2 R10: parallel, gapped, then back to back with err flag
    send_pkt(1, 188, 8'h47, 1'b0, 5);
    send_pkt(2, 188, 8'h12, 1'b1, 0);
    // R6: byte after a full packet is dropped
    send(8'h5A, 1'b0, 1'b1, 1'b0);
    // R7: cut short by a new start
    send_pkt(3, 50, 8'h47, 1'b1, 7);
    send_pkt(4, 188, 8'h47, 1'b0, 0);
    idle(10);
    chk(rd == wr, "R2 parallel drained", rd, wr);

    // R9: falling-edge launch, parallel
    cfg_fall_i = 1'b1;
    idle(4);
    send_pkt(5, 188, 8'h47, 1'b1, 11);
    idle(10);
    chk(rd == wr, "R9 falling launch drained", rd, wr);

    // R3: serial, rising then falling launch
    cfg_fall_i = 1'b0; cfg_serial_i = 1'b1;
    idle(4);
    send_pkt(6, 188, 8'h47, 1'b1, 9);
    send(8'hC3, 1'b0, 1'b0, 1'b0);
    idle(30);
    cfg_fall_i = 1'b1;
    idle(4);
    send_pkt(7, 60, 8'hB8, 1'b0, 0);
    send_pkt(8, 188, 8'h47, 1'b1, 0);
    idle(40);
    chk(rd == wr, "R3 serial drained", rd, wr);
    chk(!ts_valid_o && !ts_sync_o && !ts_err_o, "R8 final idle",
        int'({ts_valid_o, ts_sync_o, ts_err_o}), 0);
    finish_run();
  end
endmodule